// File: doc/BRIEF.md
# Byte-Wide SPI Master with Busy and Done Status

This block is a byte-wide SPI master run by an embedded microcontroller through three small registers. Software writes a byte into the data register while the master is idle. That write starts a full-duplex exchange of eight serial clock periods. The outgoing byte is shifted out most significant bit first, and the incoming bits shift into the same register. When the exchange ends, the data register holds the received byte.

Software tracks progress through an active-low busy bit in the status register. A separate sticky done flag is set at the end of every exchange and drives an interrupt line. Software clears the done flag by writing one to it. Starting the next exchange depends only on the busy bit. The state of the done flag has no effect on it.

The serial clock is the system clock divided by a fixed, even parameter. It idles low and follows SPI mode 0.

Top module: `spi_byte_master`

## Requirements
- R1: Register addresses are 0 for data, 1 for status and 2 for done. Status bit 0 reads 0 while an exchange runs and 1 otherwise. Status bits above bit 0 read 0.
- R2: After reset, status reads 01h, data reads 00h, done reads 0, and sclk_o, irq_o and mosi_o are all low.
- R3: A write to address 0 while status bit 0 is 1 loads the byte and drives status bit 0 low from the next cycle.
- R4: Status bit 0 returns to 1 exactly 8*CLK_DIV system cycles after the starting write edge, which covers eight serial clock periods.
- R5: The exchange uses mode 0. sclk_o idles low. mosi_o presents the byte MSB first and changes only with a falling sclk_o. miso_i is sampled when sclk_o rises. While idle, mosi_o shows bit 7 of the data register.
- R6: A write to address 0 while status bit 0 is 0 is dropped. The running exchange, its timing and its final result are unchanged.
- R7: After an exchange, address 0 reads the eight bits sampled from miso_i, first bit sampled in bit 7.
- R8: The done flag (address 2, bit 0) is set in the cycle in which status bit 0 returns to 1. irq_o always equals the done flag.
- R9: Writing 1 to address 2 bit 0 clears the done flag. Writing 0 leaves it unchanged. A clear that coincides with the end of an exchange loses, and the flag stays set.
- R10: A data write while idle starts a new exchange whether or not the done flag is set. The exchange never clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Write address |
| reg_wdata_i | input | DATA_W | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | DATA_W | Read data, combinational |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| irq_o | output | 1 | Done interrupt, mirrors the done flag |

## Verification
The bench builds the block with DATA_W=8 and CLK_DIV=4. With these values an exchange takes 32 cycles, so the bench can place a dropped mid-transfer write, a back-to-back start with the done flag still set, and a clear on the exact end cycle within a short run. At every cycle, a behavioural model of the counted serial clock periods and a slave that shifts out a chosen byte are compared against each register and pin. This makes the MSB-first ordering and the end-cycle set-over-clear priority directly observable.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  typedef enum logic [1:0] {
    REG_DATA   = 2'd0,
    REG_STATUS = 2'd1,
    REG_DONE   = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/spi_sclk_div.sv
module spi_sclk_div #(
  parameter int CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CNT_W'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] load_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o
);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] sr_q;
  logic [BIT_W-1:0]  bit_q;
  logic              busy_q, sclk_q, miso_q;
  logic              last_bit;

  assign last_bit = (bit_q == BIT_W'(DATA_W - 1));
  assign done_o   = busy_q && tick_i && sclk_q && last_bit;
  assign busy_o   = busy_q;
  assign sclk_o   = sclk_q;
  assign mosi_o   = sr_q[DATA_W-1];
  assign data_o   = sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      miso_q <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        sr_q   <= load_i;
        bit_q  <= '0;
        busy_q <= 1'b1;
        sclk_q <= 1'b0;
      end
    end else if (tick_i) begin
      if (!sclk_q) begin
        // rising edge: capture
        sclk_q <= 1'b1;
        miso_q <= miso_i;
      end else begin
        // falling edge: shift, next bit appears on mosi
        sclk_q <= 1'b0;
        sr_q   <= {sr_q[DATA_W-2:0], miso_q};
        bit_q  <= bit_q + BIT_W'(1);
        if (last_bit) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_done_flag.sv
module spi_done_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;  // set wins over clear
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_master_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              irq_o
);
  logic              busy_w, tick_w, done_w, flag_w;
  logic              start_w, clr_w;
  logic [DATA_W-1:0] data_w;

  assign start_w = reg_we_i && (reg_addr_i == REG_DATA);
  assign clr_w   = reg_we_i && (reg_addr_i == REG_DONE) && reg_wdata_i[0];

  spi_sclk_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_w),
    .tick_o (tick_w)
  );

  spi_shift_engine #(.DATA_W(DATA_W)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_w),
    .load_i  (reg_wdata_i),
    .tick_i  (tick_w),
    .miso_i  (miso_i),
    .busy_o  (busy_w),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .data_o  (data_w),
    .done_o  (done_w)
  );

  spi_done_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (done_w),
    .clr_i  (clr_w),
    .flag_o (flag_w)
  );

  assign irq_o = flag_w;

  always_comb begin
    unique case (rd_addr_i)
      REG_DATA:   rd_data_o = data_w;
      REG_STATUS: rd_data_o = {{(DATA_W-1){1'b0}}, ~busy_w};
      REG_DONE:   rd_data_o = {{(DATA_W-1){1'b0}}, flag_w};
      default:    rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk
  import spi_master_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [1:0]        rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              sclk_o,
  input logic              irq_o,
  input logic              busy
);
  int unsigned busy_cnt;
  logic        clr_wr;

  assign clr_wr = reg_we_i && (reg_addr_i == REG_DONE) && reg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   busy_cnt <= 0;
    else if (busy) busy_cnt <= busy_cnt + 1;
    else           busy_cnt <= 0;
  end

  a_r1_status_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == REG_STATUS) |-> (rd_data_o[DATA_W-1:1] == '0));

  a_r3_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && reg_we_i && reg_addr_i == REG_DATA) |=> busy);

  a_r4_busy_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> (busy_cnt == 8 * CLK_DIV));

  a_r5_sclk_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !sclk_o);

  a_r8_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> irq_o);

  a_r9_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_wr) |=> irq_o);
endmodule

bind spi_byte_master spi_byte_master_chk #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .rd_addr_i   (rd_addr_i),
  .rd_data_o   (rd_data_o),
  .sclk_o      (sclk_o),
  .irq_o       (irq_o),
  .busy        (busy_w)
);

// File: tb/spi_byte_master_bench.sv
module spi_byte_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int CLK_DIV    = 4;
  localparam int HALF       = CLK_DIV / 2;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              reg_we_i = 1'b0;
  logic [1:0]        reg_addr_i = 2'd0;
  logic [DATA_W-1:0] reg_wdata_i = '0;
  logic [1:0]        rd_addr_i = 2'd0;
  logic [DATA_W-1:0] rd_data_o;
  logic              sclk_o, mosi_o, irq_o;
  logic              miso_i = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit done_sum = 0;
  bit cmp_en = 0;

  spi_byte_master #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_spi_byte_master (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // reference model state
  bit                m_busy, m_flag;
  int                m_k;
  logic [DATA_W-1:0] m_tx, m_rx, m_data, m_slv;
  logic [DATA_W-1:0] slave_byte = '0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_flag = 0; m_k = 0;
      m_tx = '0; m_rx = '0; m_data = '0; m_slv = '0;
    end else begin
      bit end_now, clr;
      int t;
      end_now = 0;
      clr = reg_we_i && reg_addr_i == 2'd2 && reg_wdata_i[0];
      if (m_busy) begin
        m_k++;
        if (m_k % HALF == 0) begin
          t = m_k / HALF;
          if (t % 2 == 1) m_rx = {m_rx[DATA_W-2:0], miso_i};
          else if (t == 2 * DATA_W) begin m_busy = 0; m_data = m_rx; end_now = 1; end
          else begin m_slv = m_slv << 1; miso_i <= m_slv[DATA_W-1]; end
        end
      end else if (reg_we_i && reg_addr_i == 2'd0) begin
        m_busy = 1; m_k = 0; m_tx = reg_wdata_i; m_data = reg_wdata_i;
        m_rx = '0; m_slv = slave_byte; miso_i <= slave_byte[DATA_W-1];
      end
      if (end_now) m_flag = 1;
      else if (clr) m_flag = 0;
    end
  end

  task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [DATA_W-1:0] v);
    rd_addr_i = a; #1; v = rd_data_o;
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (cmp_en) begin
      logic [DATA_W-1:0] v;
      int fall;
      fall = (m_k / HALF) / 2;
      check("R5 sclk", {7'd0, sclk_o}, {7'd0, m_busy && ((m_k / HALF) % 2 == 1)});
      check("R5 mosi", {7'd0, mosi_o}, {7'd0, m_busy ? m_tx[DATA_W-1-fall] : m_data[DATA_W-1]});
      check("R8 irq", {7'd0, irq_o}, {7'd0, m_flag});
      rd(2'd1, v); check("R1/R4 status", v, {7'd0, !m_busy});
      rd(2'd2, v); check("R9 done", v, {7'd0, m_flag});
      if (!m_busy) begin rd(2'd0, v); check("R7 data", v, m_data); end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
    @(posedge clk_i); #(CLK_PERIOD/4);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #(CLK_PERIOD/4);
    reg_we_i = 1'b0;
  endtask

  task automatic at_neg(input logic [1:0] a, output logic [DATA_W-1:0] v);
    @(negedge clk_i); #4; rd(a, v);
  endtask

  task automatic summary;
    if (!done_sum) begin
      done_sum = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [DATA_W-1:0] v;
    #(CLK_PERIOD * 3);
    // R2: reset state while still in reset
    rd(2'd1, v); check("R2 status", v, 8'h01);
    rd(2'd0, v); check("R2 data", v, 8'h00);
    rd(2'd2, v); check("R2 done", v, 8'h00);
    check("R2 pins", {5'd0, sclk_o, irq_o, mosi_o}, 8'h00);
    #(CLK_PERIOD/4); rst_ni = 1'b1;
    cmp_en = 1;

    // first exchange
    slave_byte = 8'h5A;
    wr(2'd0, 8'hA5);
    at_neg(2'd1, v); check("R3 busy low", v, 8'h00);
    repeat (40) @(posedge clk_i);
    at_neg(2'd0, v); check("R7 rx byte", v, 8'h5A);
    check("R8 irq set", {7'd0, irq_o}, 8'h01);

    // R9: writing 0 keeps flag, writing 1 clears it
    wr(2'd2, 8'hFE);
    at_neg(2'd2, v); check("R9 write0 keeps", v, 8'h01);
    wr(2'd2, 8'h01);
    at_neg(2'd2, v); check("R9 write1 clears", v, 8'h00);

    // R6: a write during an exchange is dropped
    slave_byte = 8'hC3;
    wr(2'd0, 8'h3C);
    repeat (8) @(posedge clk_i);
    wr(2'd0, 8'hFF);
    repeat (35) @(posedge clk_i);
    at_neg(2'd0, v); check("R6 dropped write", v, 8'hC3);
    at_neg(2'd1, v); check("R6 idle after", v, 8'h01);

    // R10: start again with done still set; clear lands on end cycle
    slave_byte = 8'h81;
    wr(2'd0, 8'h7E);
    at_neg(2'd1, v); check("R10 starts with flag set", v, 8'h00);
    check("R10 flag kept", {7'd0, irq_o}, 8'h01);
    repeat (29) @(posedge clk_i);
    wr(2'd2, 8'h01);  // sampled on the end edge
    at_neg(2'd2, v); check("R9 set beats clear", v, 8'h01);
    at_neg(2'd0, v); check("R7 rx 81", v, 8'h81);
    wr(2'd2, 8'h01);
    at_neg(2'd2, v); check("R9 cleared", v, 8'h00);

    // all-zero out, all-one in
    slave_byte = 8'hFF;
    wr(2'd0, 8'h00);
    repeat (40) @(posedge clk_i);
    at_neg(2'd0, v); check("R7 rx FF", v, 8'hFF);
    check("R5 mosi idle = data msb", {7'd0, mosi_o}, 8'h01);
    repeat (4) @(posedge clk_i);
    summary();
  end
endmodule